// File: doc/BRIEF.md
# Debug Board Interrupt Expander

This block is a small word-wide register file of the sort a debug-board logic device carries. It collects five peripheral interrupt lines into one active-low parent line for the host. Each source has a sticky status bit. A status bit is set when its input goes from low to high, after the input has passed through a synchronizer. Each bit is cleared through a separate clear register. The host writes a one to the clear bit and later writes zero. While the one stays in place, the status bit is held clear. A mask register gates which status bits reach the parent line. A one in a mask bit disables that source.

Three fixed signature words let host software confirm the board is fitted. A code version word and a board identity word can also be read. An LED register and a module-reset register are plain read/write words that drive output pins. A button word reads its input pins straight through. The bus port is synchronous: address, write strobe and write data are sampled on the rising clock edge. Read data is a combinational function of the address and of the register contents.

Top module: `dbg_irq_expander`

## Requirements
- R1: Word registers are decoded from the full 8-bit byte address: LED 0x00, buttons 0x08, status 0x10, clear 0x20, mask 0x38, signature A 0x40, signature B 0x48, version 0x50, signature C 0x58, module reset 0x60, board identity 0x68.
- R2: Signature A reads 0xAAAA, signature B reads 0x5555 and signature C reads 0xCAFE. Version reads the CODE_VER parameter (default 0x0103). Board identity reads the BOARD_ID parameter (default 0x0051).
- R3: After reset the following hold. Mask reads 0x001F. Status, clear, LED and module-reset read 0x0000. The irq_n output is high.
- R4: Status bit n is set on a rising edge of src_irq[n] and then reads as one at 0x10 within four clock cycles. The bits map as follows: bit 0 Ethernet, bit 1 UART A, bit 2 UART B, bit 3 button A, bit 4 button B.
- R5: The irq_n output is low exactly when some status bit is set and its mask bit (bits 4:0 of 0x38) is zero. Masking never prevents a status bit from being set.
- R6: Writing a one to bit n of the clear register (0x20) clears status bit n. While that bit stays one, status bit n stays clear even if its source rises. Writing 0xFFFF clears all status bits. The clear register reads back bits 4:0 only.
- R7: The LED word (0x00) and the module-reset word (0x60) are 16-bit read/write registers. They appear on led_out and mod_rst_out one cycle after the write.
- R8: The button word (0x08) reads btn_in unchanged.
- R9: Reads of unmapped offsets return 0x0000. Writes to status, the signatures, version and board identity are ignored. Unused upper bits of status, mask and clear read as zero.
- R10: A status bit that is cleared while its source stays high is not set again until the source falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the word accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| src_irq | input | 5 | Peripheral interrupt inputs, active high |
| btn_in | input | 16 | Button levels shown in the button word |
| led_out | output | 16 | LED register contents |
| mod_rst_out | output | 16 | Module-reset register contents |
| irq_n | output | 1 | Parent interrupt, level, active low |

## Verification
The assertions assume three things about the inputs. The source inputs are plain levels. Each write strobe lasts a single cycle, with address and data stable around the clock edge. Reset is applied before any source rises. The stimulus changes sources and bus inputs only on falling clock edges. It holds every source pattern for at least four cycles, so each edge passes the synchronizer before the next change. Its reference model therefore sees the same rising edges as the design. Clear-register values are drawn at random, so the bench covers both held-clear windows and clears that are released at once.

// File: rtl/dbg_irq_pkg.sv
// Package: shared widths, word offsets and the decode-select type for the
// interrupt expander. Assumes an 8-bit byte address and 16-bit words.
package dbg_irq_pkg;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 8;
    localparam int NUM_SRC = 5;

    localparam logic [ADDR_W-1:0] OFF_LED  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_BTN  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_STAT = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_CLR  = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_MASK = 8'h38;
    localparam logic [ADDR_W-1:0] OFF_SIGA = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_SIGB = 8'h48;
    localparam logic [ADDR_W-1:0] OFF_VER  = 8'h50;
    localparam logic [ADDR_W-1:0] OFF_SIGC = 8'h58;
    localparam logic [ADDR_W-1:0] OFF_MRST = 8'h60;
    localparam logic [ADDR_W-1:0] OFF_BID  = 8'h68;

    localparam logic [DATA_W-1:0] SIG_A = 16'hAAAA;
    localparam logic [DATA_W-1:0] SIG_B = 16'h5555;
    localparam logic [DATA_W-1:0] SIG_C = 16'hCAFE;

    typedef struct packed {
        logic led;
        logic btn;
        logic stat;
        logic clr;
        logic mask;
        logic siga;
        logic sigb;
        logic ver;
        logic sigc;
        logic mrst;
        logic bid;
    } sel_t;
endpackage

// File: rtl/dbg_irq_sync.sv
// Module: multi-stage synchronizer plus rising-edge detector for the
// interrupt sources. Assumes sources are slow levels; reset clears all
// stages, so a source already high after reset yields one rising edge.
module dbg_irq_sync #(
    parameter int NUM_SRC     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    output logic [NUM_SRC-1:0] rise
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [NUM_SRC-1:0] stage [SYNC_STAGES];
    logic [NUM_SRC-1:0] prev_q;

    // First stage samples the raw inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= src_in;
    end

    // Remaining stages form the synchronizer chain.
    for (genvar k = 1; k < SYNC_STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage[k] <= '0;
            else        stage[k] <= stage[k-1];
        end
    end

    // Delayed copy of the synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stage[LAST];
    end

    // A rising edge is a synchronized one that was zero last cycle.
    always_comb rise = stage[LAST] & ~prev_q;
endmodule

// File: rtl/dbg_irq_core.sv
// Module: sticky status, mask and clear registers plus the active-low
// parent line. Assumes write strobes are single-cycle and already decoded.
module dbg_irq_core #(
    parameter int NUM_SRC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] rise,
    input  logic               wr_mask,
    input  logic               wr_clr,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] status,
    output logic [NUM_SRC-1:0] mask,
    output logic [NUM_SRC-1:0] clr,
    output logic               irq_n
);
    // Mask register, all sources disabled at reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '1;
        else if (wr_mask) mask <= wdata;
    end

    // Clear register, holds its value until software rewrites it.
    always_ff @(posedge clk) begin
        if (!rst_n)      clr <= '0;
        else if (wr_clr) clr <= wdata;
    end

    // Status bits latch edges and are held clear by clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status | rise) & ~clr;
    end

    // Parent line asserted low while any enabled status bit is set.
    always_comb irq_n = ~|(status & ~mask);

    a_r4_latch_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise & ~clr) != '0) |=> ((status & $past(rise & ~clr)) == $past(rise & ~clr)));

    a_r6_hold_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr != '0) |=> ((status & $past(clr)) == '0));

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~clr) != '0) |=> ((status & $past(status & ~clr)) == $past(status & ~clr)));
endmodule

// File: rtl/dbg_irq_regs.sv
// Module: address decode, plain read/write words and the read multiplexer.
// Assumes full-address decode and combinational read data.
module dbg_irq_regs
    import dbg_irq_pkg::*;
#(
    parameter int               NUM_SRC  = 5,
    parameter logic [DATA_W-1:0] CODE_VER = 16'h0103,
    parameter logic [DATA_W-1:0] BOARD_ID = 16'h0051
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [DATA_W-1:0]  btn_in,
    input  logic [NUM_SRC-1:0] status,
    input  logic [NUM_SRC-1:0] mask,
    input  logic [NUM_SRC-1:0] clr,
    output logic               wr_mask,
    output logic               wr_clr,
    output logic [DATA_W-1:0]  led_out,
    output logic [DATA_W-1:0]  mod_rst_out
);
    localparam int PAD_W = DATA_W - NUM_SRC;

    sel_t sel;

    // One-hot select of the addressed word.
    always_comb begin
        sel      = '0;
        sel.led  = (bus_addr == OFF_LED);
        sel.btn  = (bus_addr == OFF_BTN);
        sel.stat = (bus_addr == OFF_STAT);
        sel.clr  = (bus_addr == OFF_CLR);
        sel.mask = (bus_addr == OFF_MASK);
        sel.siga = (bus_addr == OFF_SIGA);
        sel.sigb = (bus_addr == OFF_SIGB);
        sel.ver  = (bus_addr == OFF_VER);
        sel.sigc = (bus_addr == OFF_SIGC);
        sel.mrst = (bus_addr == OFF_MRST);
        sel.bid  = (bus_addr == OFF_BID);
    end

    // Write strobes passed to the interrupt core.
    always_comb begin
        wr_mask = bus_wr & sel.mask;
        wr_clr  = bus_wr & sel.clr;
    end

    // LED word register.
    always_ff @(posedge clk) begin
        if (!rst_n)                led_out <= '0;
        else if (bus_wr & sel.led) led_out <= bus_wdata;
    end

    // Module-reset word register.
    always_ff @(posedge clk) begin
        if (!rst_n)                 mod_rst_out <= '0;
        else if (bus_wr & sel.mrst) mod_rst_out <= bus_wdata;
    end

    // Read multiplexer, zero for unmapped offsets.
    always_comb begin
        bus_rdata = '0;
        if (sel.led)  bus_rdata = led_out;
        if (sel.btn)  bus_rdata = btn_in;
        if (sel.stat) bus_rdata = {{PAD_W{1'b0}}, status};
        if (sel.clr)  bus_rdata = {{PAD_W{1'b0}}, clr};
        if (sel.mask) bus_rdata = {{PAD_W{1'b0}}, mask};
        if (sel.siga) bus_rdata = SIG_A;
        if (sel.sigb) bus_rdata = SIG_B;
        if (sel.ver)  bus_rdata = CODE_VER;
        if (sel.sigc) bus_rdata = SIG_C;
        if (sel.mrst) bus_rdata = mod_rst_out;
        if (sel.bid)  bus_rdata = BOARD_ID;
    end

    a_r7_led_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_LED) |=> (led_out == $past(bus_wdata)));

    a_r7_mrst_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_MRST) |=> (mod_rst_out == $past(bus_wdata)));
endmodule

// File: rtl/dbg_irq_expander.sv
// Module: top of the debug-board interrupt expander. Joins the source
// synchronizer, the interrupt core and the register bank. Assumes one
// clock domain, synchronous active-low reset.
module dbg_irq_expander
    import dbg_irq_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] CODE_VER    = 16'h0103,
    parameter logic [DATA_W-1:0] BOARD_ID    = 16'h0051
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] src_irq,
    input  logic [DATA_W-1:0]  btn_in,
    output logic [DATA_W-1:0]  led_out,
    output logic [DATA_W-1:0]  mod_rst_out,
    output logic               irq_n
);
    logic [NUM_SRC-1:0] rise_w;
    logic [NUM_SRC-1:0] status_w;
    logic [NUM_SRC-1:0] mask_w;
    logic [NUM_SRC-1:0] clr_w;
    logic               wr_mask_w;
    logic               wr_clr_w;

    dbg_irq_sync #(
        .NUM_SRC     (NUM_SRC),
        .SYNC_STAGES (SYNC_STAGES)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_in (src_irq),
        .rise   (rise_w)
    );

    dbg_irq_core #(
        .NUM_SRC (NUM_SRC)
    ) core_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (rise_w),
        .wr_mask (wr_mask_w),
        .wr_clr  (wr_clr_w),
        .wdata   (bus_wdata[NUM_SRC-1:0]),
        .status  (status_w),
        .mask    (mask_w),
        .clr     (clr_w),
        .irq_n   (irq_n)
    );

    dbg_irq_regs #(
        .NUM_SRC  (NUM_SRC),
        .CODE_VER (CODE_VER),
        .BOARD_ID (BOARD_ID)
    ) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .btn_in      (btn_in),
        .status      (status_w),
        .mask        (mask_w),
        .clr         (clr_w),
        .wr_mask     (wr_mask_w),
        .wr_clr      (wr_clr_w),
        .led_out     (led_out),
        .mod_rst_out (mod_rst_out)
    );

    a_r5_parent_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (status_w != '0));

    a_r5_full_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_MASK && (&bus_wdata[NUM_SRC-1:0])) |=> irq_n);
endmodule

// File: tb/dbg_irq_expander_tb_top.sv
`timescale 1ns/1ps
module dbg_irq_expander_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [4:0]  src_irq = '0;
    logic [15:0] btn_in = '0;
    logic [15:0] led_out;
    logic [15:0] mod_rst_out;
    logic        irq_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [4:0] m_stat = '0;
    logic [4:0] m_mask = 5'h1F;
    logic [4:0] m_clr = '0;

    always #4 clk = ~clk;

    dbg_irq_expander dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .src_irq     (src_irq),
        .btn_in      (btn_in),
        .led_out     (led_out),
        .mod_rst_out (mod_rst_out),
        .irq_n       (irq_n)
    );

    function automatic logic exp_irq_n(logic [4:0] st, logic [4:0] mk);
        return ~|(st & ~mk);
    endfunction

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_src(logic [4:0] v);
        @(negedge clk);
        m_stat = (m_stat | (v & ~src_irq)) & ~m_clr;
        src_irq = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic chk_irq(string tag);
        logic [15:0] d;
        rd(8'h10, d);
        chk({tag, " status"}, d, {11'b0, m_stat});
        chk({tag, " irq_n"}, {15'b0, irq_n}, {15'b0, exp_irq_n(m_stat, m_mask)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog got=%h exp=%h", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [7:0] ua;
        void'($urandom(32'h5EED1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 reset state
        rd(8'h38, d); chk("R3 mask", d, 16'h001F);
        rd(8'h10, d); chk("R3 status", d, 16'h0000);
        rd(8'h20, d); chk("R3 clear", d, 16'h0000);
        rd(8'h00, d); chk("R3 led", d, 16'h0000);
        rd(8'h60, d); chk("R3 modrst", d, 16'h0000);
        chk("R3 irq_n", {15'b0, irq_n}, 16'h0001);

        // R1 R2 fixed words
        rd(8'h40, d); chk("R2 sigA", d, 16'hAAAA);
        rd(8'h48, d); chk("R2 sigB", d, 16'h5555);
        rd(8'h58, d); chk("R2 sigC", d, 16'hCAFE);
        rd(8'h50, d); chk("R2 ver", d, 16'h0103);
        rd(8'h68, d); chk("R2 bid", d, 16'h0051);

        // R7 read/write words
        wr(8'h00, 16'hA5C3);
        chk("R7 led_out", led_out, 16'hA5C3);
        rd(8'h00, d); chk("R7 led read", d, 16'hA5C3);
        wr(8'h60, 16'h3C0F);
        chk("R7 mrst_out", mod_rst_out, 16'h3C0F);
        rd(8'h60, d); chk("R7 mrst read", d, 16'h3C0F);

        // R8 buttons
        btn_in = 16'h1234;
        rd(8'h08, d); chk("R8 btn", d, 16'h1234);
        btn_in = 16'hFEDC;
        rd(8'h08, d); chk("R8 btn2", d, 16'hFEDC);

        // R9 unmapped reads and read-only writes
        rd(8'h04, d); chk("R9 unmapped 04", d, 16'h0000);
        rd(8'h70, d); chk("R9 unmapped 70", d, 16'h0000);
        rd(8'h11, d); chk("R9 unmapped 11", d, 16'h0000);
        wr(8'h10, 16'hFFFF); rd(8'h10, d); chk("R9 status ro", d, 16'h0000);
        wr(8'h40, 16'h0000); rd(8'h40, d); chk("R9 sigA ro", d, 16'hAAAA);
        wr(8'h50, 16'h0000); rd(8'h50, d); chk("R9 ver ro", d, 16'h0103);
        wr(8'h68, 16'hFFFF); rd(8'h68, d); chk("R9 bid ro", d, 16'h0051);
        wr(8'h38, 16'hFFE0); m_mask = 5'h00;
        rd(8'h38, d); chk("R9 mask upper", d, 16'h0000);

        // R4 each source latches; R5 unmasked so irq low
        for (int i = 0; i < 5; i++) begin
            set_src(5'(1 << i));
            chk_irq("R4 edge");
            set_src(5'h00);
        end
        chk_irq("R4 sticky after fall");

        // R6 clear all with 0xFFFF, clear reg reads 0x1F
        wr(8'h20, 16'hFFFF); m_clr = 5'h1F; m_stat = 5'h00;
        rd(8'h20, d); chk("R6 clear readback", d, 16'h001F);
        chk_irq("R6 clear all");
        wr(8'h20, 16'h0000); m_clr = 5'h00;

        // R6 held clear suppresses a rising source
        wr(8'h20, 16'h0001); m_clr = 5'h01;
        set_src(5'h01);
        chk_irq("R6 held clear");
        wr(8'h20, 16'h0000); m_clr = 5'h00;
        chk_irq("R10 no relatch after release");
        set_src(5'h00);
        set_src(5'h01);
        chk_irq("R10 new edge latches");

        // R10 clear while source still high
        wr(8'h20, 16'h0001); m_clr = 5'h01; m_stat = m_stat & ~5'h01;
        wr(8'h20, 16'h0000); m_clr = 5'h00;
        chk_irq("R10 cleared level source");
        set_src(5'h00);

        // R5 mask gating
        wr(8'h38, 16'h001F); m_mask = 5'h1F;
        set_src(5'h08);
        chk_irq("R5 masked still latches");
        wr(8'h38, 16'h0017); m_mask = 5'h17;
        chk_irq("R5 unmask asserts");
        wr(8'h38, 16'h001F); m_mask = 5'h1F;
        chk_irq("R5 remask releases");
        set_src(5'h00);

        // Random mix for R4 R5 R6
        for (int n = 0; n < 400; n++) begin
            int op;
            logic [4:0] v;
            op = int'($urandom_range(0, 3));
            v = 5'($urandom());
            case (op)
                0, 1: set_src(v);
                2: begin wr(8'h38, {11'($urandom()), v}); m_mask = v; end
                default: begin
                    if ($urandom_range(0, 1) == 0) v = 5'h00;
                    wr(8'h20, {11'($urandom()), v}); m_clr = v;
                    m_stat = m_stat & ~v;
                end
            endcase
            chk_irq("R4R5R6 random");
        end

        // R9 random unmapped offsets
        for (int n = 0; n < 20; n++) begin
            ua = 8'($urandom());
            if (ua[2:0] != 3'b000 || ua > 8'h68 || ua == 8'h18 || ua == 8'h28 ||
                ua == 8'h30) begin
                rd(ua, d); chk("R9 random unmapped", d, 16'h0000);
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule